// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers a configurable number of interrupt lines, up to 32, and drives one interrupt request towards a processor. At build time each line is made either edge-triggered or level-triggered. A line that fires sets a bit in a status register, and that bit stays set until software clears it. An enable register masks the status bits to form the pending set. The lowest-numbered pending line is reported as a vector index. A two-bit master control gates the request output.

Software sees eight 32-bit word registers through a plain read/write port. A write takes effect at the clock edge on which it is presented. A read is combinational on the address. Enable bits can be changed one at a time, with no read-modify-write: one register sets bits and another clears them. Acknowledge is write-one-to-clear. The vector register reads all ones when nothing is pending, so the dispatch code can test for one sentinel value.

Top module: `irq_vec_ctrl`

## Requirements
- R1: The word index is `reg_addr_i[4:2]` and the bits [1:0] are ignored. The byte offsets are: 0x00 status (read), 0x04 pending (read), 0x08 enable (read/write), 0x0C acknowledge (write), 0x10 enable-set (write), 0x14 enable-clear (write), 0x18 vector (read), 0x1C master control (read/write). A read of 0x0C, 0x10 or 0x14 returns 0.
- R2: An edge-kind line sets its status bit on the edge after the line goes from 0 to 1 between two successive samples. The bit then holds while the line stays high or goes low, until it is acknowledged.
- R3: A level-kind line sets its status bit on every edge where it is high. An acknowledge of that bit wins in its own cycle, so the bit reads 0 right after the acknowledge and reads 1 again one edge later if the line is still high. A rising edge on an edge-kind line wins over an acknowledge in the same cycle.
- R4: A write to the acknowledge register clears exactly the status bits at positions written as 1. Other status bits are left as they are.
- R5: A write to enable-set sets the enable bits at the positions written as 1, and a write to enable-clear clears them. All other enable bits keep their values.
- R6: A direct write to the enable register replaces all enable bits. Writing 0 masks every line.
- R7: The pending register reads as status AND enable.
- R8: The vector register reads the index of the lowest-numbered pending line. It reads 0xFFFFFFFF when no line is pending.
- R9: In the master control register, bit 0 is the global enable and bit 1 is the output enable. Both bits read back as last written, and bits 31:2 read 0.
- R10: `irq_req_o` is a registered signal. On each edge it takes the OR of the pending bits, ANDed with both master bits, as those values stood before that edge.
- R11: While `rst_n` is low on a clock edge, that edge clears status, enable, master control and `irq_req_o`. The vector then reads 0xFFFFFFFF.
- R12: The `KIND_MASK` parameter sets the trigger kind for each line: 1 gives an edge line and 0 a level line. Mask bits at or above `NUM_SRC` are ignored. Register bits at or above `NUM_SRC` read 0, whatever is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_src_i | input | NUM_SRC | Interrupt lines |
| reg_addr_i | input | 5 | Register byte address |
| reg_wr_i | input | 1 | Write strobe for one cycle |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| irq_req_o | output | 1 | Interrupt request to the processor |

## Verification
The embedded assertions check the following on every cycle:
- Edge-kind status bits hold until they are acknowledged.
- An acknowledged level bit clears.
- Enable-set and enable-clear writes land on the written bits.
- The vector names the lowest pending line, or all ones when none is pending.
- The request follows the gated pending OR one cycle later.
- Reset clears the state.

Other behaviour can only be shown by the bench scenarios. These cover:
- The read map, including write-only words reading 0.
- A level line coming back one cycle after its acknowledge.
- An edge winning over an acknowledge in the same cycle.
- The master bits reading back exactly as written.
- The unused upper bits reading 0.

// File: rtl/ivc_pkg.sv
// Package: shared register word indices for the vectored interrupt controller.
// Assumes word-aligned access; the index is address bits [4:2].
package ivc_pkg;
    typedef enum logic [2:0] {
        W_STATUS = 3'd0,
        W_PEND   = 3'd1,
        W_ENABLE = 3'd2,
        W_ACK    = 3'd3,
        W_ENSET  = 3'd4,
        W_ENCLR  = 3'd5,
        W_VECTOR = 3'd6,
        W_MASTER = 3'd7
    } ivc_word_e;

    localparam int unsigned REG_W = 32;
endpackage

// File: rtl/ivc_capture.sv
// Module: per-line trigger detection and status latching.
// Edge lines latch on a rise versus the last registered sample; level lines
// latch every cycle they are high. Acknowledge clears; an edge rise beats an
// acknowledge in the same cycle, an acknowledge beats a level set.
// Assumes the lines are already synchronous to clk.
module ivc_capture #(
    parameter int unsigned NUM_SRC   = 8,
    parameter logic [31:0] KIND_MASK = 32'h0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [NUM_SRC-1:0] ack_i,
    output logic [NUM_SRC-1:0] status_o
);
    localparam logic [NUM_SRC-1:0] EDGE_K = KIND_MASK[NUM_SRC-1:0];

    logic [NUM_SRC-1:0] src_q;
    logic [NUM_SRC-1:0] set_edge;
    logic [NUM_SRC-1:0] set_lvl;

    // Purpose: form per-line set requests from the two trigger kinds.
    always_comb begin
        set_edge = src_i & ~src_q & EDGE_K;
        set_lvl  = src_i & ~EDGE_K;
    end

    // Purpose: keep the previous sample and update the status bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q    <= '0;
            status_o <= '0;
        end else begin
            src_q    <= src_i;
            status_o <= (status_o & ~ack_i) | set_edge | (set_lvl & ~ack_i);
        end
    end

    // R2: an edge status bit not being acknowledged stays set.
    p_edge_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_o & $past(status_o & ~ack_i & EDGE_K))
                  == $past(status_o & ~ack_i & EDGE_K)));

    // R3: an acknowledged level bit reads cleared after the edge.
    p_ack_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((ack_i & ~EDGE_K) != '0) |=> ((status_o & $past(ack_i & ~EDGE_K)) == '0));
endmodule

// File: rtl/ivc_prio.sv
// Module: fixed-priority encoder, lowest index wins.
// Assumes NUM_SRC >= 1; idx_o is meaningful only when hit_o is set.
module ivc_prio #(
    parameter int unsigned NUM_SRC = 8,
    localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] req_i,
    output logic               hit_o,
    output logic [IDX_W-1:0]   idx_o
);
    // Purpose: scan from the top so the lowest set bit is the last to win.
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                hit_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_vec_ctrl.sv
// Module: vectored interrupt controller top.
// Holds the enable and master control registers, decodes register writes,
// muxes reads and registers the request output. Writes take effect on the
// edge where reg_wr_i is high; reads are combinational on reg_addr_i.
// Assumes 1 <= NUM_SRC <= 32.
module irq_vec_ctrl
    import ivc_pkg::*;
#(
    parameter int unsigned NUM_SRC   = 8,
    parameter logic [31:0] KIND_MASK = 32'hFFFF_FF0F
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_src_i,
    input  logic [4:0]         reg_addr_i,
    input  logic               reg_wr_i,
    input  logic [31:0]        reg_wdata_i,
    output logic [31:0]        reg_rdata_o,
    output logic               irq_req_o
);
    localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    ivc_word_e          word;
    logic [NUM_SRC-1:0] wmask;
    logic [NUM_SRC-1:0] ack_vec;
    logic [NUM_SRC-1:0] status;
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] pending;
    logic [1:0]         master_q;
    logic               vec_hit;
    logic [IDX_W-1:0]   vec_idx;
    logic [31:0]        vector;

    // Purpose: decode the word index and the per-line write data.
    always_comb begin
        word    = ivc_word_e'(reg_addr_i[4:2]);
        wmask   = reg_wdata_i[NUM_SRC-1:0];
        ack_vec = (reg_wr_i && word == W_ACK) ? wmask : '0;
    end

    ivc_capture #(.NUM_SRC(NUM_SRC), .KIND_MASK(KIND_MASK)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (irq_src_i),
        .ack_i    (ack_vec),
        .status_o (status)
    );

    // Purpose: update the enable and master registers from writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= '0;
            master_q <= 2'b00;
        end else if (reg_wr_i) begin
            case (word)
                W_ENABLE: en_q     <= wmask;
                W_ENSET:  en_q     <= en_q | wmask;
                W_ENCLR:  en_q     <= en_q & ~wmask;
                W_MASTER: master_q <= reg_wdata_i[1:0];
                default:  ;
            endcase
        end
    end

    assign pending = status & en_q;

    ivc_prio #(.NUM_SRC(NUM_SRC)) u_prio (
        .req_i (pending),
        .hit_o (vec_hit),
        .idx_o (vec_idx)
    );

    assign vector = vec_hit ? 32'(vec_idx) : 32'hFFFF_FFFF;

    // Purpose: register the gated request output.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_req_o <= 1'b0;
        else        irq_req_o <= (|pending) & master_q[0] & master_q[1];
    end

    // Purpose: select the read data for the addressed word.
    always_comb begin
        case (word)
            W_STATUS: reg_rdata_o = 32'(status);
            W_PEND:   reg_rdata_o = 32'(pending);
            W_ENABLE: reg_rdata_o = 32'(en_q);
            W_VECTOR: reg_rdata_o = vector;
            W_MASTER: reg_rdata_o = {30'd0, master_q};
            default:  reg_rdata_o = 32'd0;
        endcase
    end

    // R5: enable-set makes the written bits 1.
    p_enset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && word == W_ENSET) |=> ((en_q & $past(wmask)) == $past(wmask)));

    // R5: enable-clear makes the written bits 0.
    p_enclr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && word == W_ENCLR) |=> ((en_q & $past(wmask)) == '0));

    // R8: nothing pending gives the all-ones vector.
    p_vec_none_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pending == '0) |-> (vector == 32'hFFFF_FFFF));

    // R8: the vector names a pending line with none below it.
    p_vec_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pending != '0) |-> (pending[vec_idx] &&
            ((pending & ~({NUM_SRC{1'b1}} << vec_idx)) == '0)));

    // R10: request only when both master bits and some pending line were present.
    p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && irq_req_o) |->
            ($past(master_q) == 2'b11 && $past(pending) != '0));

    // R10: gated pending produces the request one edge later.
    p_irq_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((|pending) && master_q == 2'b11) |=> irq_req_o);

    // R11: reset clears enable, master and request.
    p_reset_r11: assert property (@(posedge clk)
        !rst_n |=> (en_q == '0 && master_q == 2'b00 && !irq_req_o));
endmodule

// File: tb/irq_vec_ctrl_bench.sv
`timescale 1ns/1ps
module irq_vec_ctrl_bench;
    localparam int unsigned NSRC = 8;
    // Lines 0..3 edge, 4..7 level, upper mask bits set but ignored (R12).

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src = '0;
    logic [4:0]      addr = 5'd0;
    logic            wr = 1'b0;
    logic [31:0]     wdata = 32'd0;
    logic [31:0]     rdata;
    logic            irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    irq_vec_ctrl #(.NUM_SRC(NSRC), .KIND_MASK(32'hFFFF_FF0F)) u_irq_vec_ctrl (
        .clk (clk), .rst_n (rst_n), .irq_src_i (src), .reg_addr_i (addr),
        .reg_wr_i (wr), .reg_wdata_i (wdata), .reg_rdata_o (rdata), .irq_req_o (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [4:0] a, output logic [31:0] d);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic clean();
        src = '0;
        step();
        wr_reg(5'h0C, 32'hFFFF_FFFF);
        wr_reg(5'h08, 32'd0);
        wr_reg(5'h1C, 32'd0);
        step();
    endtask

    // R11 / R1: reset state and read map.
    task automatic t_reset();
        logic [31:0] v;
        rd_reg(5'h00, v); chk("R11 status after reset", v, 0);
        rd_reg(5'h08, v); chk("R11 enable after reset", v, 0);
        rd_reg(5'h1C, v); chk("R11 master after reset", v, 0);
        rd_reg(5'h18, v); chk("R11 vector after reset", v, 32'hFFFF_FFFF);
        chk("R11 irq after reset", 32'(irq), 0);
        wr_reg(5'h08, 32'h0000_00A5);
        rd_reg(5'h10, v); chk("R1 enable-set reads 0", v, 0);
        rd_reg(5'h14, v); chk("R1 enable-clear reads 0", v, 0);
        rd_reg(5'h0C, v); chk("R1 ack reads 0", v, 0);
        rd_reg(5'h0B, v); chk("R1 low address bits ignored", v, 32'hA5);
    endtask

    // R2: edge line latch and hold.
    task automatic t_edge();
        logic [31:0] v;
        clean();
        src[0] = 1'b1; step();
        rd_reg(5'h00, v); chk("R2 edge latched", v, 32'h1);
        src[0] = 1'b0; step(); step();
        rd_reg(5'h00, v); chk("R2 edge holds after line low", v, 32'h1);
        src[0] = 1'b1; step();
        wr_reg(5'h0C, 32'h1);
        step();
        rd_reg(5'h00, v); chk("R2 held-high edge line stays cleared", v, 0);
        src[0] = 1'b0; step();
        @(negedge clk);
        addr = 5'h0C; wdata = 32'h1; wr = 1'b1; src[0] = 1'b1;
        @(negedge clk);
        wr = 1'b0;
        rd_reg(5'h00, v); chk("R3 edge rise beats ack", v, 32'h1);
    endtask

    // R3: level line set, ack, re-set.
    task automatic t_level();
        logic [31:0] v;
        clean();
        src[4] = 1'b1; step();
        rd_reg(5'h00, v); chk("R3 level latched", v, 32'h10);
        wr_reg(5'h0C, 32'h10);
        rd_reg(5'h00, v); chk("R3 level cleared right after ack", v, 0);
        step();
        rd_reg(5'h00, v); chk("R3 level re-set while high", v, 32'h10);
        src[4] = 1'b0; step();
        wr_reg(5'h0C, 32'h10); step();
        rd_reg(5'h00, v); chk("R3 level stays clear when low", v, 0);
    endtask

    // R4: ack clears only written positions.
    task automatic t_ack_mask();
        logic [31:0] v;
        clean();
        src[2:0] = 3'b111; step();
        src[2:0] = 3'b000; step();
        wr_reg(5'h0C, 32'h5);
        rd_reg(5'h00, v); chk("R4 partial ack", v, 32'h2);
    endtask

    // R5/R6/R7/R8/R12: enables, pending and vector.
    task automatic t_enable_vector();
        logic [31:0] v;
        clean();
        src[2:1] = 2'b11; step();
        src[2:1] = 2'b00; step();
        rd_reg(5'h18, v); chk("R8 vector none enabled", v, 32'hFFFF_FFFF);
        wr_reg(5'h10, 32'h06);
        wr_reg(5'h10, 32'h80);
        rd_reg(5'h08, v); chk("R5 set-enable accumulates", v, 32'h86);
        rd_reg(5'h04, v); chk("R7 pending is status and enable", v, 32'h06);
        rd_reg(5'h18, v); chk("R8 lowest pending wins", v, 32'd1);
        wr_reg(5'h14, 32'h02);
        rd_reg(5'h08, v); chk("R5 clear-enable touches only written bits", v, 32'h84);
        rd_reg(5'h18, v); chk("R8 next line after clear", v, 32'd2);
        wr_reg(5'h08, 32'd0);
        rd_reg(5'h04, v); chk("R6 enable write of 0 masks all", v, 0);
        rd_reg(5'h18, v); chk("R8 all ones when masked", v, 32'hFFFF_FFFF);
        wr_reg(5'h08, 32'hFFFF_FFFF);
        rd_reg(5'h08, v); chk("R12 enable upper bits read 0", v, 32'hFF);
        rd_reg(5'h00, v); chk("R12 status upper bits read 0", v, 32'h06);
    endtask

    // R9/R10: master bits and request timing.
    task automatic t_master_irq();
        logic [31:0] v;
        clean();
        wr_reg(5'h1C, 32'hFFFF_FFFF);
        rd_reg(5'h1C, v); chk("R9 master readback", v, 32'h3);
        wr_reg(5'h1C, 32'h1);
        rd_reg(5'h1C, v); chk("R9 master single bit", v, 32'h1);
        wr_reg(5'h08, 32'h08);
        src[3] = 1'b1; step(); src[3] = 1'b0; step(); step();
        chk("R10 no request with one master bit", 32'(irq), 0);
        wr_reg(5'h1C, 32'h2); step();
        chk("R10 no request with other master bit", 32'(irq), 0);
        wr_reg(5'h1C, 32'h3);
        chk("R10 request not yet on write edge", 32'(irq), 0);
        step();
        chk("R10 request one edge later", 32'(irq), 1);
        wr_reg(5'h0C, 32'h08);
        chk("R10 request still up on ack edge", 32'(irq), 1);
        step();
        chk("R10 request drops after ack", 32'(irq), 0);
        src[3] = 1'b1; step();
        rst_n = 1'b0; step(); rst_n = 1'b1;
        src[3] = 1'b0;
        chk("R11 irq cleared by reset", 32'(irq), 0);
        rd_reg(5'h00, v); chk("R11 status cleared by reset", v, 0);
        rd_reg(5'h1C, v); chk("R11 master cleared by reset", v, 0);
    endtask

    initial begin
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_edge();
        t_level();
        t_ack_mask();
        t_enable_vector();
        t_master_irq();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule